// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

The block holds two 16-bit timer/counters. Each one keeps its count in a low byte and a high byte that software can read and write on their own. One shared configuration register picks the mode of each timer. For each timer it also sets whether the timer paces itself on the machine-cycle tick or counts falling edges of its own count pin, and whether an external gate pin must be high for it to advance. A second register holds the two run bits. The oscillator is divided into machine cycles outside the block, which sees that division only as a single-cycle `tick` strobe. Every timer state change tied to time happens in a clock cycle where `tick` is high.

There are four modes per timer. The first is an 8-bit counter behind a divide-by-32 prescaler. The second is a full 16-bit counter. The third is an 8-bit counter that reloads itself from the high byte. The fourth is a special mode whose behaviour depends on the timer. In that mode timer 1 freezes. Timer 0 breaks into two independent 8-bit counters, and the upper one borrows timer 1's run bit and overflow flag. An overflow raises a sticky flag, which is offered to an external interrupt controller. When the controller vectors to that interrupt, it pulses the matching acknowledge input.

Top module: `dtc_top`

## Requirements
- R1: After reset every readable register (addresses 0 to 5) reads 0x00 and both overflow flags are low.
- R2: Register map: address 0 is the configuration register, 1 is control, 2 and 3 are the low and high bytes of timer 0, and 4 and 5 are the same for timer 1. In timer mode a running timer advances by one on each cycle with `tick` high and never on a cycle without it.
- R3: With the counter-select bit set, a timer advances only when a `tick` finds its count pin low after the previous `tick` sampled it high. Pin movement between two ticks that ends at the same level is not counted.
- R4: With the gate bit set, a timer advances only while its run bit is 1 and its gate pin is high. With the run bit at 0 it never advances.
- R5: Mode 00: bits 4:0 of the low byte act as a divide-by-32 prescaler. Each time they wrap from 31 to 0, the high byte increments. Bits 7:5 of the low byte hold. An overflow is a wrap of the high byte from 0xFF.
- R6: Mode 01: the two bytes form one 16-bit count. A wrap from 0xFFFF to 0x0000 is an overflow.
- R7: Mode 10: the low byte counts. When it overflows from 0xFF it is loaded with the high byte, and the high byte is left unchanged.
- R8: Timer 1 in mode 11 holds both of its bytes whatever the run, gate and tick inputs do.
- R9: Timer 0 in mode 11 splits in two. The low byte is an 8-bit counter that uses timer 0's own controls and flag. The high byte counts ticks whenever timer 1's run bit is set and raises flag 1. While this split is active, timer 1's own overflow raises no flag.
- R10: An overflow sets the timer's flag. Acknowledge bit i clears flag i, but if an overflow of the same timer falls in the same cycle, the flag stays set.
- R11: A write to a count byte takes priority over an increment in the same cycle. That timer's increment and overflow for the cycle are dropped (in split mode this applies only to the half being written).
- R12: Configuration bit layout per nibble (timer 0 in bits 3:0, timer 1 in 7:4): mode in bits 1:0, counter-select in bit 2, gate in bit 3. Control register: bit 0 is run 0, bit 1 is run 1, and bits 3:2 read back the flags. Both registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| cnt_in | input | 2 | External count pins, one per timer |
| gate_in | input | 2 | External gate pins, one per timer |
| irq_ack | input | 2 | Interrupt-acknowledge pulses, one per timer |
| ovf_flag | output | 2 | Overflow flags, one per timer |

## Verification
Two collisions can fall in the same cycle. A software write to a count byte can meet a tick increment, and an overflow can meet an acknowledge. The bench provokes each one with a single cycle that carries both `tick` and `wr_en`, or both `tick` and `irq_ack`. In the first case it checks that the written byte holds the written value and not that value plus one. It also checks that a write to the high byte at 0xFFFF leaves the low byte alone and raises no flag. In the second case it checks that the flag stays set after the collision cycle.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    M_PRESC   = 2'b00,
    M_FULL    = 2'b01,
    M_RELOAD  = 2'b10,
    M_SPECIAL = 2'b11
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   cnt_sel;
    tmode_e mode;
  } tcfg_t;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;
endpackage

// File: rtl/dtc_edge.sv
module dtc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_smp
    logic smp_q;
    logic smp_n;

    always_comb begin
      smp_n = tick ? pin[i] : smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= 1'b0;
      else        smp_q <= smp_n;
    end

    assign fall[i] = tick & smp_q & ~pin[i];
  end
endmodule

// File: rtl/dtc_core.sv
module dtc_core
  import dtc_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE      = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  tcfg_t        cfg,
  input  logic         run,
  input  logic         gate_pin,
  input  logic         fall,
  input  logic         run_alt,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         ovf_main,
  output logic         ovf_alt
);
  localparam logic [PRE-1:0] ONE_P = {{(PRE-1){1'b0}}, 1'b1};
  localparam logic [W-1:0]   ONE_W = {{(W-1){1'b0}}, 1'b1};
  localparam logic [2*W-1:0] ONE_D = {{(2*W-1){1'b0}}, 1'b1};

  logic [W-1:0] lo_n, hi_n;
  logic en, step, split_act, inc, alt_inc, upd;

  always_comb begin
    en        = run & (~cfg.gate | gate_pin);
    step      = cfg.cnt_sel ? fall : tick;
    split_act = SPLIT_OK & (cfg.mode == M_SPECIAL);
    inc       = en & step & ~(split_act ? wr_lo : (wr_lo | wr_hi));
    alt_inc   = split_act & tick & run_alt & ~wr_hi;
    upd       = tick | wr_lo | wr_hi;
  end

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_main = 1'b0;
    ovf_alt  = 1'b0;
    case (cfg.mode)
      M_PRESC: if (inc) begin
        lo_n[PRE-1:0] = lo_q[PRE-1:0] + ONE_P;
        if (&lo_q[PRE-1:0]) begin
          hi_n     = hi_q + ONE_W;
          ovf_main = &hi_q;
        end
      end
      M_FULL: if (inc) begin
        {hi_n, lo_n} = {hi_q, lo_q} + ONE_D;
        ovf_main     = &{hi_q, lo_q};
      end
      M_RELOAD: if (inc) begin
        if (&lo_q) begin
          lo_n     = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_n = lo_q + ONE_W;
        end
      end
      default: if (split_act) begin
        if (inc) begin
          lo_n     = lo_q + ONE_W;
          ovf_main = &lo_q;
        end
        if (alt_inc) begin
          hi_n    = hi_q + ONE_W;
          ovf_alt = &hi_q;
        end
      end
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (upd) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  // R11
  wr_lo_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wr_data));

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi && !split_act) |=> ($stable(lo_q) && $stable(hi_q)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == M_RELOAD && ovf_main && !wr_lo) |=> lo_q == $past(hi_q));

  if (!SPLIT_OK) begin : g_freeze_chk
    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == M_SPECIAL && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
  end
endmodule

// File: rtl/dtc_top.sv
module dtc_top
  import dtc_pkg::*;
#(
  parameter int PRE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [1:0]        cnt_in,
  input  logic [1:0]        gate_in,
  input  logic [1:0]        irq_ack,
  output logic [1:0]        ovf_flag
);
  localparam int NT    = 2;
  localparam int CFG_W = $bits(tcfg_t);

  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic [NT*CFG_W-1:0] cfg_q, cfg_n;
  logic [NT-1:0]       run_q, run_n, flag_q, flag_n, set;
  logic [NT-1:0]       fall, ovf_main, ovf_alt;
  logic [BYTE_W-1:0]   lo_q [NT];
  logic [BYTE_W-1:0]   hi_q [NT];
  tcfg_t               cfg  [NT];
  logic                wr_cfg, wr_ctrl, split0;

  assign wr_cfg  = wr_en && (wr_addr == A_CFG);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

  dtc_edge #(.N(NT)) u_edge (
    .clk(clk), .rst_n(rst_s), .tick(tick), .pin(cnt_in), .fall(fall)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic wr_lo, wr_hi;
    assign cfg[i] = tcfg_t'(cfg_q[i*CFG_W +: CFG_W]);
    assign wr_lo  = wr_en && (wr_addr == ((i == 0) ? A_LO0 : A_LO1));
    assign wr_hi  = wr_en && (wr_addr == ((i == 0) ? A_HI0 : A_HI1));

    dtc_core #(.W(BYTE_W), .PRE(PRE), .SPLIT_OK(i == 0)) u_core (
      .clk(clk), .rst_n(rst_s), .tick(tick), .cfg(cfg[i]), .run(run_q[i]),
      .gate_pin(gate_in[i]), .fall(fall[i]), .run_alt(run_q[1]),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
      .lo_q(lo_q[i]), .hi_q(hi_q[i]),
      .ovf_main(ovf_main[i]), .ovf_alt(ovf_alt[i])
    );
  end

  always_comb begin
    split0 = (cfg[0].mode == M_SPECIAL);
    set[0] = ovf_main[0];
    set[1] = split0 ? ovf_alt[0] : (ovf_main[1] | ovf_alt[1]);
    flag_n = set | (flag_q & ~irq_ack);
    cfg_n  = wr_cfg  ? wr_data[NT*CFG_W-1:0] : cfg_q;
    run_n  = wr_ctrl ? wr_data[NT-1:0]       : run_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      cfg_q  <= cfg_n;
      run_q  <= run_n;
      flag_q <= flag_n;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_data = cfg_q;
      A_CTRL:  rd_data = {4'b0000, flag_q, run_q};
      A_LO0:   rd_data = lo_q[0];
      A_HI0:   rd_data = hi_q[0];
      A_LO1:   rd_data = lo_q[1];
      A_HI1:   rd_data = hi_q[1];
      default: rd_data = '0;
    endcase
  end

  assign ovf_flag = flag_q;

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (|set) |=> ((ovf_flag & $past(set)) == $past(set)));

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_ack[0] && !set[0]) |=> !ovf_flag[0]);

  // R12
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    wr_ctrl |=> run_q == $past(wr_data[NT-1:0]));
endmodule

// File: tb/dtc_top_tb.sv
module dtc_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_in = '0, gate_in = '0, irq_ack = '0;
  logic [1:0] ovf_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dtc_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_in(cnt_in),
    .gate_in(gate_in), .irq_ack(irq_ack), .ovf_flag(ovf_flag)
  );

  // {mode, preset lo, preset hi, ticks, expect lo, expect hi, expect flag}
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {2'b01, 8'hFE, 8'hFF, 8'd3,  8'h01, 8'h00, 1'b1},
    {2'b01, 8'h00, 8'h00, 8'd5,  8'h05, 8'h00, 1'b0},
    {2'b10, 8'hFD, 8'h80, 8'd4,  8'h81, 8'h80, 1'b1},
    {2'b00, 8'h1E, 8'hFF, 8'd2,  8'h00, 8'h00, 1'b1},
    {2'b00, 8'hE0, 8'h10, 8'd32, 8'hE0, 8'h11, 1'b0},
    {2'b10, 8'hFF, 8'hFF, 8'd2,  8'hFF, 8'hFF, 1'b1},
    {2'b00, 8'h3F, 8'h7F, 8'd1,  8'h20, 8'h80, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic we, input logic [2:0] a,
                     input logic [7:0] d, input logic [1:0] ak);
    @(negedge clk);
    tick = t; wr_en = we; wr_addr = a; wr_data = d; irq_ack = ak;
    @(posedge clk);
    #1;
    tick = 1'b0; wr_en = 1'b0; irq_ack = 2'b00;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d, 2'b00);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 3'd0, 8'h00, 2'b00);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset flags", {6'b0, ovf_flag}, 8'h00);

    // R12 readback
    wr(3'd0, 8'hA5); rd(3'd0, v); chk("R12 cfg readback", v, 8'hA5);
    wr(3'd1, 8'h03); rd(3'd1, v); chk("R12 ctrl readback", v, 8'h03);
    wr(3'd1, 8'h00);

    // Vector table: timer 0, timer mode, R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [42:0] e;
      e = VEC[i];
      tag = (e[42:41] == 2'b00) ? "R5" : (e[42:41] == 2'b01) ? "R6" : "R7";
      wr(3'd1, 8'h00);
      cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b11);
      wr(3'd0, {6'b0, e[42:41]});
      wr(3'd2, e[40:33]);
      wr(3'd3, e[32:25]);
      wr(3'd1, 8'h01);
      ticks(int'(e[24:17]));
      wr(3'd1, 8'h00);
      rd(3'd2, v); chk({tag, " lo"}, v, e[16:9]);
      rd(3'd3, v); chk({tag, " hi"}, v, e[8:1]);
      chk({tag, " flag"}, {7'b0, ovf_flag[0]}, {7'b0, e[0]});
    end

    // R2: no tick, no count
    wr(3'd0, 8'h01); wr(3'd2, 8'h07); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    repeat (3) cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b00);
    rd(3'd2, v); chk("R2 idle without tick", v, 8'h07);
    ticks(1); rd(3'd2, v); chk("R2 one tick", v, 8'h08);

    // R3 counter mode on falling edges
    wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    cnt_in[0] = 1'b1; ticks(1);
    cnt_in[0] = 1'b0; ticks(1);
    ticks(1);
    cnt_in[0] = 1'b1; ticks(1);
    cnt_in[0] = 1'b0; ticks(1);
    rd(3'd2, v); chk("R3 edge count", v, 8'h02);
    cnt_in[0] = 1'b1; cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b00);
    cnt_in[0] = 1'b0; ticks(1);
    rd(3'd2, v); chk("R3 unsampled pulse", v, 8'h02);

    // R4 gating
    wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    gate_in[0] = 1'b0; ticks(3);
    rd(3'd2, v); chk("R4 gate low", v, 8'h00);
    gate_in[0] = 1'b1; ticks(3);
    rd(3'd2, v); chk("R4 gate high", v, 8'h03);
    wr(3'd1, 8'h00); ticks(2);
    rd(3'd2, v); chk("R4 run off", v, 8'h03);
    gate_in[0] = 1'b0;

    // R8 timer 1 frozen in mode 11
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b11);
    wr(3'd0, 8'h30); wr(3'd4, 8'h12); wr(3'd5, 8'h34); wr(3'd1, 8'h02);
    ticks(5);
    rd(3'd4, v); chk("R8 t1 lo", v, 8'h12);
    rd(3'd5, v); chk("R8 t1 hi", v, 8'h34);
    chk("R8 t1 flag", {7'b0, ovf_flag[1]}, 8'h00);

    // R9 split timer 0
    wr(3'd1, 8'h00); cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b11);
    wr(3'd0, 8'h13); wr(3'd2, 8'hFF); wr(3'd3, 8'hFE); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h03); ticks(2);
    rd(3'd2, v); chk("R9 split lo", v, 8'h01);
    rd(3'd3, v); chk("R9 split hi", v, 8'h00);
    chk("R9 split flags", {6'b0, ovf_flag}, 8'h03);
    rd(3'd4, v); chk("R9 t1 runs", v, 8'h02);
    wr(3'd1, 8'h00); cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b11);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h03); ticks(1);
    rd(3'd4, v); chk("R9 t1 wrapped", v, 8'h00);
    chk("R9 t1 ovf no flag", {6'b0, ovf_flag}, 8'h00);
    wr(3'd1, 8'h02); ticks(2);
    rd(3'd2, v); chk("R9 lo needs run0", v, 8'h01);
    rd(3'd3, v); chk("R9 hi on run1", v, 8'h03);

    // R10 flag clear and collision
    wr(3'd1, 8'h00); cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b11);
    wr(3'd0, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    ticks(1);
    chk("R10 flag set", {7'b0, ovf_flag[0]}, 8'h01);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b01);
    chk("R10 flag cleared", {7'b0, ovf_flag[0]}, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    ticks(1);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    cyc(1'b1, 1'b0, 3'd0, 8'h00, 2'b01);
    chk("R10 set beats ack", {7'b0, ovf_flag[0]}, 8'h01);

    // R11 write vs increment
    wr(3'd1, 8'h00); cyc(1'b0, 1'b0, 3'd0, 8'h00, 2'b11);
    wr(3'd2, 8'h05); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    cyc(1'b1, 1'b1, 3'd2, 8'h40, 2'b00);
    rd(3'd2, v); chk("R11 write wins lo", v, 8'h40);
    rd(3'd3, v); chk("R11 hi untouched", v, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    cyc(1'b1, 1'b1, 3'd3, 8'h12, 2'b00);
    rd(3'd3, v); chk("R11 write wins hi", v, 8'h12);
    rd(3'd2, v); chk("R11 lo not stepped", v, 8'hFF);
    chk("R11 no overflow", {7'b0, ovf_flag[0]}, 8'h00);

    done = 1;
    summary();
  end
endmodule